// File: doc/BRIEF.md
# Byte-Wide Loader for a Double-Buffered 16-Bit DAC

This block lets a host with an 8-bit write bus load a converter that takes a 16-bit parallel word into a two-rank latch pair. The host first writes the upper byte, which is kept in a holding register. It then writes the lower byte. On that second write the block drives the converter's chip-select and first-rank load strobe low together, so all sixteen bits enter the first rank in one event. The converter therefore never holds a word that is half old and half new. A separate commit command raises the converter's second-rank update strobe. The update pulses of several converters can be lined up this way.

The low strobe pair stays asserted for a number of clock cycles derived from the clock period and the minimum pulse width. The data word is then held for a further hold window. No write is accepted during the pulse or the hold window. An update pulse is never raised while a first-rank load or its hold window is in progress. A commit that arrives then is deferred. A low-byte write that arrives while the update strobe is high is ignored, so the first rank never loads while the second rank is open. An option inverts the top bit of the word, which lets the converter take two's-complement codes.

Top module: `byte_dac_loader`

## Requirements
- R1: After reset `dac_select_n` and `dac_stage_ld_n` are 1 and `dac_update` is 0. `dac_data` is 0x0000, or 0x8000 when `TWOS_COMP`=1.
- R2: A write with `bus_addr`=0 while no load is in progress puts `bus_wdata` on `dac_data[15:8]` from the next cycle. The strobes do not assert.
- R3: A write with `bus_addr`=1 while no load is in progress and `dac_update` is low puts `bus_wdata` on `dac_data[7:0]`. From the next cycle it drives `dac_select_n` and `dac_stage_ld_n` low together, with the full word already valid.
- R4: The strobe pair stays low for exactly LOAD = max(1, ceil(`MIN_PULSE_PS`/`CLK_PERIOD_PS`)) cycles.
- R5: `dac_data` stays unchanged from the start of the pulse through `HOLD_CYCLES` cycles after the strobes return high. Writes of either kind inside that window are ignored. A write in the first cycle after the window is accepted.
- R6: A commit while idle drives `dac_update` high from the next cycle for exactly `UPDATE_CYCLES` cycles. The strobe pair stays high.
- R7: `dac_update` is never high during a load pulse or its hold window. A commit made during one is issued on the (`HOLD_CYCLES`+1)th clock edge after the strobes return high.
- R8: A low-byte write while `dac_update` is high is ignored: no pulse, and `dac_data[7:0]` keeps its value.
- R9: A commit while `dac_update` is already high is queued. After the current pulse, one low cycle follows, then a second full pulse.
- R10: With `TWOS_COMP`=1, `dac_data[15]` is the inverse of bit 7 of the stored high byte. All other bits are unchanged.
- R11: A low-byte write and a commit in the same cycle start the load first. The update follows as in R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wdata | input | BYTE_W | Host write byte |
| bus_wr | input | 1 | Host write strobe, one cycle per write |
| bus_addr | input | 1 | 0 = high byte to holding register, 1 = low byte and first-rank load |
| bus_commit | input | 1 | Request a second-rank update pulse |
| dac_data | output | 2*BYTE_W | Word to the converter: holding register above, low byte below |
| dac_select_n | output | 1 | Converter chip select, active low |
| dac_stage_ld_n | output | 1 | Converter first-rank load strobe, active low |
| dac_update | output | 1 | Converter second-rank update strobe, active high |

## Verification
The bench builds two copies from the same stimulus. One uses a 20 ns clock period against a 50 ns minimum pulse, with two hold cycles, two update cycles and straight binary. This gives a three-cycle pulse, in which writes and commits can land in the middle of the pulse and on the last hold cycle. The other uses a 10 ns minimum pulse, one hold cycle, one update cycle and two's-complement coding. This reaches the one-cycle pulse floor of the ceiling computation and the inverted top bit.

// File: rtl/bdl_pkg.sv
package bdl_pkg;
   typedef enum logic [1:0] {
      PH_IDLE  = 2'd0,
      PH_PULSE = 2'd1,
      PH_HOLD  = 2'd2
   } ph_t;

   function automatic int ceil_div(input int num, input int den);
      return (num + den - 1) / den;
   endfunction

   function automatic int max2(input int a, input int b);
      return (a > b) ? a : b;
   endfunction
endpackage

// File: rtl/bdl_byte_reg.sv
module bdl_byte_reg #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         en,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   initial begin
      assert (W >= 1) else $error("bdl_byte_reg: W must be at least 1");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (en) q <= d;
   end
endmodule

// File: rtl/bdl_load_seq.sv
module bdl_load_seq
   import bdl_pkg::*;
#(
   parameter int LOAD_CYCLES = 2,
   parameter int HOLD_CYCLES = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic idle,
   output logic sel_n
);
   localparam int MAXC = max2(LOAD_CYCLES, HOLD_CYCLES);
   localparam int CW   = $clog2(MAXC + 1);
   localparam logic [CW-1:0] LOAD_M1 = CW'(LOAD_CYCLES - 1);
   localparam logic [CW-1:0] HOLD_M1 = CW'(HOLD_CYCLES - 1);

   initial begin
      assert (LOAD_CYCLES >= 1) else $error("bdl_load_seq: LOAD_CYCLES must be at least 1");
      assert (HOLD_CYCLES >= 1) else $error("bdl_load_seq: HOLD_CYCLES must be at least 1");
   end

   ph_t           ph_q;
   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q  <= PH_IDLE;
         cnt_q <= '0;
      end else begin
         unique case (ph_q)
            PH_IDLE: if (start) begin
               ph_q  <= PH_PULSE;
               cnt_q <= LOAD_M1;
            end
            PH_PULSE: if (cnt_q == '0) begin
               ph_q  <= PH_HOLD;
               cnt_q <= HOLD_M1;
            end else begin
               cnt_q <= cnt_q - 1'b1;
            end
            PH_HOLD: if (cnt_q == '0) begin
               ph_q <= PH_IDLE;
            end else begin
               cnt_q <= cnt_q - 1'b1;
            end
            default: ph_q <= PH_IDLE;
         endcase
      end
   end

   assign idle  = (ph_q == PH_IDLE);
   assign sel_n = (ph_q != PH_PULSE);

   // checker: length of each low strobe run
   localparam int RW = $clog2(LOAD_CYCLES + 2);
   logic [RW-1:0] low_run_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      low_run_q <= '0;
      else if (!sel_n) low_run_q <= low_run_q + 1'b1;
      else             low_run_q <= '0;
   end

   assert_pulse_width_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sel_n) |-> (low_run_q == RW'(LOAD_CYCLES)))
      else $error("strobe pulse length differs from LOAD_CYCLES");

   assert_start_pulls_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (start && idle) |=> !sel_n)
      else $error("accepted start did not assert strobe");
endmodule

// File: rtl/bdl_update_gen.sv
module bdl_update_gen #(
   parameter int UPDATE_CYCLES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic commit,
   input  logic load_idle,
   input  logic load_start,
   output logic update
);
   localparam int CW = $clog2(UPDATE_CYCLES + 1);
   localparam logic [CW-1:0] UPD_M1 = CW'(UPDATE_CYCLES - 1);

   initial begin
      assert (UPDATE_CYCLES >= 1) else $error("bdl_update_gen: UPDATE_CYCLES must be at least 1");
   end

   logic          pend_q;
   logic [CW-1:0] cnt_q;
   logic          want;
   logic          fire;

   assign want = pend_q | commit;
   assign fire = want & load_idle & ~load_start & ~update;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= 1'b0;
         update <= 1'b0;
         cnt_q  <= '0;
      end else begin
         pend_q <= want & ~fire;
         if (fire) begin
            update <= 1'b1;
            cnt_q  <= UPD_M1;
         end else if (update) begin
            if (cnt_q == '0) update <= 1'b0;
            else             cnt_q  <= cnt_q - 1'b1;
         end
      end
   end

   // checker: length of each high run
   localparam int RW = $clog2(UPDATE_CYCLES + 2);
   logic [RW-1:0] hi_run_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      hi_run_q <= '0;
      else if (update) hi_run_q <= hi_run_q + 1'b1;
      else             hi_run_q <= '0;
   end

   assert_update_width_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(update) |-> (hi_run_q == RW'(UPDATE_CYCLES)))
      else $error("update pulse length differs from UPDATE_CYCLES");

   assert_commit_not_lost_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (commit && update) |=> (pend_q || update))
      else $error("commit during update pulse was dropped");
endmodule

// File: rtl/byte_dac_loader.sv
module byte_dac_loader
   import bdl_pkg::*;
#(
   parameter int BYTE_W        = 8,
   parameter int CLK_PERIOD_PS = 20000,
   parameter int MIN_PULSE_PS  = 40000,
   parameter int HOLD_CYCLES   = 1,
   parameter int UPDATE_CYCLES = 2,
   parameter bit TWOS_COMP     = 1'b0
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [BYTE_W-1:0]     bus_wdata,
   input  logic                  bus_wr,
   input  logic                  bus_addr,
   input  logic                  bus_commit,
   output logic [2*BYTE_W-1:0]   dac_data,
   output logic                  dac_select_n,
   output logic                  dac_stage_ld_n,
   output logic                  dac_update
);
   localparam int WORD_W      = 2 * BYTE_W;
   localparam int LOAD_CYCLES = max2(1, ceil_div(MIN_PULSE_PS, CLK_PERIOD_PS));

   initial begin
      assert (BYTE_W >= 2)        else $error("byte_dac_loader: BYTE_W must be at least 2");
      assert (CLK_PERIOD_PS >= 1) else $error("byte_dac_loader: CLK_PERIOD_PS must be positive");
      assert (MIN_PULSE_PS >= 0)  else $error("byte_dac_loader: MIN_PULSE_PS must not be negative");
   end

   logic              load_idle;
   logic              strobe_n;
   logic              hi_en;
   logic              load_start;
   logic [BYTE_W-1:0] hi_q;
   logic [BYTE_W-1:0] lo_q;

   assign hi_en      = bus_wr & ~bus_addr & load_idle;
   assign load_start = bus_wr &  bus_addr & load_idle & ~dac_update;

   bdl_byte_reg #(.W(BYTE_W)) u_hi (
      .clk(clk), .rst_n(rst_n), .en(hi_en), .d(bus_wdata), .q(hi_q));

   bdl_byte_reg #(.W(BYTE_W)) u_lo (
      .clk(clk), .rst_n(rst_n), .en(load_start), .d(bus_wdata), .q(lo_q));

   bdl_load_seq #(.LOAD_CYCLES(LOAD_CYCLES), .HOLD_CYCLES(HOLD_CYCLES)) u_seq (
      .clk(clk), .rst_n(rst_n), .start(load_start),
      .idle(load_idle), .sel_n(strobe_n));

   bdl_update_gen #(.UPDATE_CYCLES(UPDATE_CYCLES)) u_upd (
      .clk(clk), .rst_n(rst_n), .commit(bus_commit),
      .load_idle(load_idle), .load_start(load_start), .update(dac_update));

   assign dac_select_n   = strobe_n;
   assign dac_stage_ld_n = strobe_n;

   generate
      if (TWOS_COMP) begin : g_twos
         assign dac_data = {~hi_q[BYTE_W-1], hi_q[BYTE_W-2:0], lo_q};
      end else begin : g_binary
         assign dac_data = {hi_q, lo_q};
      end
   endgenerate

   assert_no_update_in_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !(dac_update && !load_idle))
      else $error("update strobe high during load window");

   assert_word_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(!load_idle) && !load_idle) |-> $stable(dac_data))
      else $error("word changed inside load window");

   assert_blocked_by_update_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr && dac_update) |=> (dac_select_n && $stable(dac_data[BYTE_W-1:0])))
      else $error("low-byte write accepted during update pulse");

   assert_hi_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && !bus_addr && load_idle) |=> (dac_select_n &&
         (dac_data[WORD_W-2:BYTE_W] == $past(bus_wdata[BYTE_W-2:0]))))
      else $error("high byte not captured");
endmodule

// File: tb/byte_dac_loader_test.sv
module byte_dac_loader_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  bus_wdata = '0;
   logic        bus_wr = 1'b0;
   logic        bus_addr = 1'b0;
   logic        bus_commit = 1'b0;
   logic [15:0] data_a, data_b;
   logic        sel_a, stg_a, upd_a, sel_b, stg_b, upd_b;
   int          checks = 0;
   int          failures = 0;
   bit          done = 1'b0;

   always #10 clk = ~clk;

   // uut: LOAD=3, HOLD=2, UPDATE=2, binary
   byte_dac_loader #(.BYTE_W(8), .CLK_PERIOD_PS(20000), .MIN_PULSE_PS(50000),
      .HOLD_CYCLES(2), .UPDATE_CYCLES(2), .TWOS_COMP(1'b0)) uut (
      .clk(clk), .rst_n(rst_n), .bus_wdata(bus_wdata), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_commit(bus_commit), .dac_data(data_a),
      .dac_select_n(sel_a), .dac_stage_ld_n(stg_a), .dac_update(upd_a));

   // second copy: LOAD=1, HOLD=1, UPDATE=1, two's complement
   byte_dac_loader #(.BYTE_W(8), .CLK_PERIOD_PS(20000), .MIN_PULSE_PS(10000),
      .HOLD_CYCLES(1), .UPDATE_CYCLES(1), .TWOS_COMP(1'b1)) uut_tc (
      .clk(clk), .rst_n(rst_n), .bus_wdata(bus_wdata), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_commit(bus_commit), .dac_data(data_b),
      .dac_select_n(sel_b), .dac_stage_ld_n(stg_b), .dac_update(upd_b));

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   // one host cycle; returns at the negedge after the capturing edge
   task automatic bus(input logic wr, input logic addr, input logic [7:0] d, input logic cm);
      bus_wr = wr; bus_addr = addr; bus_wdata = d; bus_commit = cm;
      @(negedge clk);
      bus_wr = 1'b0; bus_commit = 1'b0;
   endtask

   task automatic t_reset_r1();
      chk("R1 select_n", {31'd0, sel_a}, 32'd1);
      chk("R1 stage_ld_n", {31'd0, stg_a}, 32'd1);
      chk("R1 update", {31'd0, upd_a}, 32'd0);
      chk("R1 data binary", {16'd0, data_a}, 32'h0000);
      chk("R1 data twos", {16'd0, data_b}, 32'h8000);
   endtask

   task automatic t_high_r2();
      bus(1'b1, 1'b0, 8'hA5, 1'b0);
      chk("R2 high byte", {16'd0, data_a}, 32'hA500);
      chk("R2 no strobe", {31'd0, sel_a}, 32'd1);
      idle(2);
   endtask

   task automatic t_load_r3_r4();
      int low_a = 0;
      int low_b = 0;
      bus(1'b1, 1'b1, 8'h3C, 1'b0);
      chk("R3 select low", {31'd0, sel_a}, 32'd0);
      chk("R3 stage low together", {31'd0, stg_a}, 32'd0);
      chk("R3 word valid", {16'd0, data_a}, 32'hA53C);
      for (int k = 0; k < 8; k++) begin
         if (!sel_a) low_a++;
         if (!sel_b) low_b++;
         @(negedge clk);
      end
      chk("R4 pulse length 3", low_a, 32'd3);
      chk("R4 pulse length floor 1", low_b, 32'd1);
      idle(2);
   endtask

   task automatic t_window_r5();
      logic ok = 1'b1;
      bus(1'b1, 1'b1, 8'h11, 1'b0);           // t1
      bus(1'b1, 1'b0, 8'hFF, 1'b0);           // edge E+1: ignored, now t2
      bus(1'b1, 1'b1, 8'h22, 1'b0);           // edge E+2: ignored, now t3
      for (int k = 0; k < 2; k++) begin       // t3, t4
         if (data_a !== 16'hA511) ok = 1'b0;
         @(negedge clk);
      end
      chk("R5 stable in pulse and hold", {31'd0, ok}, 32'd1);
      bus(1'b1, 1'b0, 8'h77, 1'b0);           // edge E+5: last hold cycle, ignored
      chk("R5 last hold write ignored", {16'd0, data_a}, 32'hA511);
      bus(1'b1, 1'b0, 8'h66, 1'b0);           // edge E+6: accepted
      chk("R5 write after window accepted", {16'd0, data_a}, 32'h6611);
      chk("R5 no second pulse", {31'd0, sel_a}, 32'd1);
      idle(6);
   endtask

   task automatic t_twos_r10();
      bus(1'b1, 1'b0, 8'h12, 1'b0);
      bus(1'b1, 1'b1, 8'h34, 1'b0);
      chk("R10 binary word", {16'd0, data_a}, 32'h1234);
      chk("R10 msb inverted", {16'd0, data_b}, 32'h9234);
      idle(8);
   endtask

   task automatic t_commit_r6();
      bus(1'b0, 1'b0, 8'h00, 1'b1);
      chk("R6 update cycle 1", {31'd0, upd_a}, 32'd1);
      chk("R6 strobes stay high", {31'd0, sel_a}, 32'd1);
      idle(1);
      chk("R6 update cycle 2", {31'd0, upd_a}, 32'd1);
      idle(1);
      chk("R6 update ends", {31'd0, upd_a}, 32'd0);
      idle(4);
   endtask

   task automatic deferred_update(input string req);
      logic seen = 1'b0;
      for (int k = 0; k < 5; k++) begin       // t2..t6
         if (upd_a) seen = 1'b1;
         @(negedge clk);
      end
      chk({req, " no update in window"}, {31'd0, seen}, 32'd0);
      chk({req, " update at hold+1 edge"}, {31'd0, upd_a}, 32'd1);
   endtask

   task automatic t_defer_r7();
      bus(1'b1, 1'b1, 8'h5A, 1'b0);           // t1
      chk("R7 update low at pulse start", {31'd0, upd_a}, 32'd0);
      bus(1'b0, 1'b0, 8'h00, 1'b1);           // commit at E+1, now t2
      deferred_update("R7");
      idle(8);
   endtask

   task automatic t_blocked_r8();
      bus(1'b0, 1'b0, 8'h00, 1'b1);           // update high
      bus(1'b1, 1'b1, 8'h99, 1'b0);           // write during update
      chk("R8 no pulse", {31'd0, sel_a}, 32'd1);
      chk("R8 low byte kept", {24'd0, data_a[7:0]}, 32'h5A);
      idle(3);
      chk("R8 still no pulse", {31'd0, sel_a}, 32'd1);
      idle(4);
   endtask

   task automatic t_requeue_r9();
      logic [5:0] seq = '0;
      bus(1'b0, 1'b0, 8'h00, 1'b1);           // t1
      seq[0] = upd_a;
      bus(1'b0, 1'b0, 8'h00, 1'b1);           // t2
      for (int k = 1; k < 6; k++) begin
         seq[k] = upd_a;
         @(negedge clk);
      end
      chk("R9 pulse gap pulse", {26'd0, seq}, 32'b011011);
      idle(4);
   endtask

   task automatic t_same_r11();
      bus(1'b1, 1'b1, 8'h0F, 1'b1);           // t1
      chk("R11 load first", {31'd0, sel_a}, 32'd0);
      chk("R11 update held off", {31'd0, upd_a}, 32'd0);
      @(negedge clk);                         // t2
      deferred_update("R11");
      idle(6);
   endtask

   initial begin
      idle(3);
      rst_n = 1'b1;
      idle(1);
      t_reset_r1();
      t_high_r2();
      t_load_r3_r4();
      t_window_r5();
      t_twos_r10();
      t_commit_r6();
      t_defer_r7();
      t_blocked_r8();
      t_requeue_r9();
      t_same_r11();
      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule